// File: doc/BRIEF.md
# Segmented Current-Steering DAC Switch Decoder

This block turns a binary sample word into the switch controls of a segmented current-steering converter. The sample is split into two fields. The upper field is expanded into a unary (thermometer) code, one line per equal-sized unit current cell. The lower field is routed straight to a set of binary-weighted cells. With the default sizing, a 16-bit word becomes 63 unit lines plus 10 binary lines, 73 controls in all. Each unit cell carries 2^10 LSB, which is twice the weight of the largest binary cell.

A sample is accepted when its valid flag is high on a rising clock edge. Every control line comes from one register stage, so the whole output word changes on a single edge and no cell switches ahead of the others. When no valid sample arrives, the outputs keep their last value. Reset clears every line, which selects zero output current. The split point is a parameter; setting the unary field to 3 bits, for example, gives 7 unit lines and binary lines for the remaining bits.

Top module: `seg_dac_decoder`

## Requirements
- R1: While reset is asserted, all unit lines and all binary lines are 0.
- R2: Unit line i (i = 0 .. 2^SEG_W-2) is 1 exactly when the upper field, code bits [DATA_W-1:DATA_W-SEG_W] (bits [15:10] by default), read as an unsigned number, is greater than i.
- R3: Binary line k equals code bit k for k = 0 .. DATA_W-SEG_W-1 (bits [9:0] by default); line k carries weight 2^k.
- R4: For every input code, the number of active unit lines times 2^(DATA_W-SEG_W), plus the binary lines read as an unsigned number, equals the code.
- R5: A sample taken with valid high at a rising edge appears on all outputs right after that edge, and not before it.
- R6: A rising edge with valid low leaves every output unchanged, whatever the code input carries.
- R7: The active unit lines always form one unbroken run starting at line 0: line i high implies line i-1 high.
- R8: Code 0 gives all lines low; the all-ones code gives all 2^SEG_W-1 unit lines and all binary lines high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; samples and outputs move on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | High when smp_code_i carries a sample to convert |
| smp_code_i | input | DATA_W (16) | Unsigned sample word |
| unit_sel_o | output | 2^SEG_W-1 (63) | Unit cell controls, thermometer coded |
| bin_sel_o | output | DATA_W-SEG_W (10) | Binary-weighted cell controls |

## Verification
The hardest situation to reach is a boundary in the upper field where the unit count changes by one while the lower field wraps from all ones to all zeros, since this is where a faulty decoder gives a large step in the summed weight. The stimulus walks every one of the 65536 codes in ascending order, one per clock, so each such carry boundary is crossed and the total weight is checked against the code on both sides of it. Hold behaviour is reached by leaving valid low while the code input is swept to values that would change every output.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;

    // Default split of the sample word
    localparam int unsigned DATA_W_DEF = 16;
    localparam int unsigned SEG_W_DEF  = 6;

    // Number of unit lines for a unary field of width w
    function automatic int unsigned unit_count(input int unsigned w);
        return (1 << w) - 1;
    endfunction

endpackage

// File: rtl/seg_dac_split.sv
module seg_dac_split #(
    parameter int unsigned DATA_W = seg_dac_pkg::DATA_W_DEF,
    parameter int unsigned SEG_W  = seg_dac_pkg::SEG_W_DEF,
    localparam int unsigned BIN_W = DATA_W - SEG_W
) (
    input  logic [DATA_W-1:0] code_i,
    output logic [SEG_W-1:0]  upper_o,
    output logic [BIN_W-1:0]  lower_o
);

    assign upper_o = code_i[DATA_W-1:BIN_W];
    assign lower_o = code_i[BIN_W-1:0];

endmodule

// File: rtl/seg_dac_therm.sv
module seg_dac_therm #(
    parameter int unsigned SEG_W   = seg_dac_pkg::SEG_W_DEF,
    localparam int unsigned UNIT_N = (1 << SEG_W) - 1
) (
    input  logic [SEG_W-1:0]  upper_i,
    output logic [UNIT_N-1:0] unit_o
);

    // One magnitude comparison per unit line
    for (genvar gi = 0; gi < UNIT_N; gi++) begin : g_line
        assign unit_o[gi] = (upper_i > SEG_W'(gi));
    end

endmodule

// File: rtl/seg_dac_decoder.sv
module seg_dac_decoder #(
    parameter int unsigned DATA_W = seg_dac_pkg::DATA_W_DEF,
    parameter int unsigned SEG_W  = seg_dac_pkg::SEG_W_DEF,
    localparam int unsigned BIN_W  = DATA_W - SEG_W,
    localparam int unsigned UNIT_N = (1 << SEG_W) - 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              smp_valid_i,
    input  logic [DATA_W-1:0] smp_code_i,
    output logic [UNIT_N-1:0] unit_sel_o,
    output logic [BIN_W-1:0]  bin_sel_o
);

    typedef struct packed {
        logic [UNIT_N-1:0] unit;
        logic [BIN_W-1:0]  bin;
    } sel_t;

    logic [SEG_W-1:0]  upper_w;
    logic [BIN_W-1:0]  lower_w;
    logic [UNIT_N-1:0] unit_w;

    sel_t sel_d, sel_q;

    seg_dac_split #(
        .DATA_W (DATA_W),
        .SEG_W  (SEG_W)
    ) i_split (
        .code_i  (smp_code_i),
        .upper_o (upper_w),
        .lower_o (lower_w)
    );

    seg_dac_therm #(
        .SEG_W (SEG_W)
    ) i_therm (
        .upper_i (upper_w),
        .unit_o  (unit_w)
    );

    always_comb begin
        sel_d = sel_q;
        if (smp_valid_i) begin
            sel_d.unit = unit_w;
            sel_d.bin  = lower_w;
        end
    end

    // Single register stage: all controls switch on the same edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign unit_sel_o = sel_q.unit;
    assign bin_sel_o  = sel_q.bin;

endmodule

// File: rtl/seg_dac_decoder_chk.sv
module seg_dac_decoder_chk #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned SEG_W  = 6,
    localparam int unsigned BIN_W  = DATA_W - SEG_W,
    localparam int unsigned UNIT_N = (1 << SEG_W) - 1
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              smp_valid_i,
    input logic [DATA_W-1:0] smp_code_i,
    input logic [UNIT_N-1:0] unit_sel_o,
    input logic [BIN_W-1:0]  bin_sel_o
);

    logic [DATA_W:0] weight_w;
    assign weight_w = ((DATA_W+1)'($countones(unit_sel_o)) << BIN_W)
                      + (DATA_W+1)'(bin_sel_o);

    // R1
    always @(posedge clk_i) begin
        if (!rst_ni) begin
            reset_clear_chk: assert (unit_sel_o == '0 && bin_sel_o == '0);
        end
    end

    // R4
    property p_weight;
        @(posedge clk_i) disable iff (!rst_ni)
        smp_valid_i |=> weight_w == (DATA_W+1)'($past(smp_code_i));
    endproperty
    weight_match_chk: assert property (p_weight);

    // R5
    property p_lower;
        @(posedge clk_i) disable iff (!rst_ni)
        smp_valid_i |=> bin_sel_o == $past(smp_code_i[BIN_W-1:0]);
    endproperty
    lower_pass_chk: assert property (p_lower);

    // R6
    property p_hold;
        @(posedge clk_i) disable iff (!rst_ni)
        !smp_valid_i |=> $stable(unit_sel_o) && $stable(bin_sel_o);
    endproperty
    hold_idle_chk: assert property (p_hold);

    // R7
    property p_run;
        @(posedge clk_i) disable iff (!rst_ni)
        (unit_sel_o & ~{unit_sel_o[UNIT_N-2:0], 1'b1}) == '0;
    endproperty
    unit_run_chk: assert property (p_run);

endmodule

bind seg_dac_decoder seg_dac_decoder_chk #(
    .DATA_W (DATA_W),
    .SEG_W  (SEG_W)
) i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .smp_valid_i (smp_valid_i),
    .smp_code_i  (smp_code_i),
    .unit_sel_o  (unit_sel_o),
    .bin_sel_o   (bin_sel_o)
);

// File: tb/test_seg_dac_decoder.sv
`timescale 1ns/1ps
module test_seg_dac_decoder;

    localparam int DATA_W = 16;
    localparam int SEG_W  = 6;
    localparam int BIN_W  = DATA_W - SEG_W;
    localparam int UNIT_N = (1 << SEG_W) - 1;

    logic              clk_i = 1'b0;
    logic              rst_ni = 1'b0;
    logic              smp_valid_i = 1'b0;
    logic [DATA_W-1:0] smp_code_i = '0;
    logic [UNIT_N-1:0] unit_sel_o;
    logic [BIN_W-1:0]  bin_sel_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk_i = ~clk_i;

    seg_dac_decoder #(.DATA_W(DATA_W), .SEG_W(SEG_W)) i_seg_dac_decoder (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .smp_valid_i (smp_valid_i),
        .smp_code_i  (smp_code_i),
        .unit_sel_o  (unit_sel_o),
        .bin_sel_o   (bin_sel_o)
    );

    function automatic logic [UNIT_N-1:0] exp_unit(input logic [DATA_W-1:0] c);
        logic [UNIT_N-1:0] r;
        int up;
        up = int'(c) / (1 << BIN_W);
        for (int i = 0; i < UNIT_N; i++) r[i] = (up > i);
        return r;
    endfunction

    task automatic check(input string req, input logic [UNIT_N:0] act,
                         input logic [UNIT_N:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input logic [DATA_W-1:0] c);
        int cnt;
        int wsum;
        bit gap;
        cnt = 0;
        gap = 1'b0;
        for (int i = 0; i < UNIT_N; i++) begin
            if (unit_sel_o[i]) cnt++;
            if (i > 0 && unit_sel_o[i] && !unit_sel_o[i-1]) gap = 1'b1;
        end
        wsum = cnt * (1 << BIN_W) + int'(bin_sel_o);
        check("R2", {1'b0, unit_sel_o}, {1'b0, exp_unit(c)});
        check("R3", (UNIT_N+1)'(bin_sel_o), (UNIT_N+1)'(int'(c) % (1 << BIN_W)));
        check("R4", (UNIT_N+1)'(wsum), (UNIT_N+1)'(c));
        check("R7", (UNIT_N+1)'(gap), '0);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk_i);
        check("R1", {1'b0, unit_sel_o}, '0);
        check("R1", (UNIT_N+1)'(bin_sel_o), '0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R1", {1'b0, unit_sel_o}, '0);

        // R5: nothing moves before the edge that takes the sample
        smp_valid_i = 1'b1;
        smp_code_i  = 16'hA5C3;
        #2;
        check("R5", {1'b0, unit_sel_o}, '0);
        check("R5", (UNIT_N+1)'(bin_sel_o), '0);
        @(negedge clk_i);
        check("R5", {1'b0, unit_sel_o}, {1'b0, exp_unit(16'hA5C3)});
        check("R5", (UNIT_N+1)'(bin_sel_o), (UNIT_N+1)'(10'h1C3));

        // R2 R3 R4 R7: every code, ascending, one per clock
        for (int c = 0; c < (1 << DATA_W); c++) begin
            smp_code_i = DATA_W'(c);
            @(negedge clk_i);
            check_all(DATA_W'(c));
        end

        // R8: the two end points
        smp_code_i = '0;
        @(negedge clk_i);
        check("R8", {1'b0, unit_sel_o}, '0);
        check("R8", (UNIT_N+1)'(bin_sel_o), '0);
        smp_code_i = '1;
        @(negedge clk_i);
        check("R8", {1'b0, unit_sel_o}, {1'b0, {UNIT_N{1'b1}}});
        check("R8", (UNIT_N+1)'(bin_sel_o), (UNIT_N+1)'({BIN_W{1'b1}}));

        // R6: valid low, code sweeps; outputs keep the all-ones sample
        smp_valid_i = 1'b0;
        for (int k = 0; k < 64; k++) begin
            smp_code_i = DATA_W'(k * 1021);
            @(negedge clk_i);
            check("R6", {1'b0, unit_sel_o}, {1'b0, {UNIT_N{1'b1}}});
            check("R6", (UNIT_N+1)'(bin_sel_o), (UNIT_N+1)'({BIN_W{1'b1}}));
        end
        // R6: a valid sample after the idle stretch is taken normally
        smp_valid_i = 1'b1;
        smp_code_i  = 16'h0400;
        @(negedge clk_i);
        check_all(16'h0400);
        smp_valid_i = 1'b0;
        smp_code_i  = 16'hFFFF;
        @(negedge clk_i);
        check_all(16'h0400);

        // R1: reset in mid-run clears everything
        rst_ni = 1'b0;
        #1;
        check("R1", {1'b0, unit_sel_o}, '0);
        check("R1", (UNIT_N+1)'(bin_sel_o), '0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_i);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule